// File: doc/BRIEF.md
# DMA Terminal Count Generator

This block sits beside a disk controller's data channel and tells the controller when a transfer has moved the number of bytes that software asked for. The DMA engine that moves the bytes does not report this itself. The block therefore watches the engine's active-low acknowledge strobe and counts one step for each acknowledge. When the count reaches a preset value, it sends the controller a terminal-count pulse. The pulse is held back by a fixed number of clocks, and it reaches the controller only while a separate enable input is high.

Before a transfer, software loads the preset (the maximum count) and clears or loads the running count through a small write port. It then raises the enable. Once the preset is reached, the count freezes. The block then ignores further acknowledges until software loads or clears the count again. The block also passes the controller's DMA request on to the DMA engine through a short fixed delay line.

Top module: `dma_tc_gen`

## Requirements
- R1: The acknowledge input `dack_n` is active low. It passes through a two-flop synchronizer. Each high-to-low transition advances `cnt_q` by exactly one, three clock edges after the low level is first sampled. An acknowledge held low for many clocks counts only once.
- R2: A write with `reg_we`=1 and `reg_addr`=0 loads `reg_wdata` into the preset. A write with `reg_addr`=1 loads `reg_wdata` into the running count. A `cnt_clr` pulse sets the count to zero and takes priority over a count write. A software count update takes priority over an acknowledge in the same cycle.
- R3: The preset is matched when an acknowledge moves the count to a value equal to a nonzero preset. On a match, `cnt_q` holds that value and a terminal-count pulse is scheduled.
- R4: `tc` is active high. It rises exactly TC_DELAY clocks after the edge on which `cnt_q` reaches the preset. It stays high for exactly TC_WIDTH clocks, once per match.
- R5: `tc` stays 0 whenever `tc_en` is 0. The scheduled pulse is then lost.
- R6: After a match, acknowledges leave `cnt_q` unchanged until software writes the count or pulses `cnt_clr`. Either action also cancels a pulse that is pending or in progress.
- R7: `drq_out` equals `drq_in` delayed by REQ_DELAY clocks. With REQ_DELAY=0 it is a direct connection.
- R8: A preset of zero never produces a `tc` pulse, even when the count wraps around.
- R9: After reset, `cnt_q`, the preset, `tc` and `drq_out` are all 0, and no pulse is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Write target: 0 preset, 1 running count |
| reg_wdata | input | CNT_W | Write data |
| cnt_clr | input | 1 | Clears the running count and the freeze |
| tc_en | input | 1 | Lets the terminal-count pulse reach `tc` |
| dack_n | input | 1 | DMA acknowledge, active low, asynchronous |
| drq_in | input | 1 | DMA request from the disk controller |
| drq_out | output | 1 | Delayed DMA request toward the DMA engine |
| tc | output | 1 | Terminal-count pulse, active high |
| cnt_q | output | CNT_W | Running acknowledge count |

## Verification
The hardest state to reach from the ports is a pending terminal count that software cancels. Reaching it needs a matching acknowledge, after which software must act inside the TC_DELAY window before `tc` rises. The bench uses a short delay and issues `cnt_clr` two clocks after the count is seen at the preset. The other case is a count that wraps while the preset is zero, which needs more acknowledges than the counter can hold. A 4-bit counter makes that reachable in 20 strobes. Every preset from 1 to 7 is swept with the enable both off and on, and the rise cycle and the pulse length are measured.

// File: rtl/dma_tc_pkg.sv
package dma_tc_pkg;
   typedef enum logic [1:0] {
      TC_IDLE  = 2'd0,
      TC_WAIT  = 2'd1,
      TC_PULSE = 2'd2
   } tc_state_e;
endpackage

// File: rtl/dma_tc_ack_detect.sv
module dma_tc_ack_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic fall_evt
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         last_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_n};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign fall_evt = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/dma_tc_req_delay.sv
module dma_tc_req_delay #(
   parameter int DEPTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else if (DEPTH == 1) begin : g_one
         logic r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= 1'b0;
            else        r_q <= d;
         end
         assign q = r_q;
      end else begin : g_chain
         logic [DEPTH-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[DEPTH-2:0], d};
         end
         assign q = sh_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/dma_tc_timer.sv
module dma_tc_timer
   import dma_tc_pkg::*;
#(
   parameter int DLY = 144,
   parameter int WID = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   output logic pulse
);
   localparam int SPAN = (DLY > WID) ? DLY : WID;
   localparam int TW   = $clog2(SPAN + 1);

   tc_state_e      st_q;
   logic [TW-1:0]  tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TC_IDLE;
         tmr_q <= '0;
      end else if (abort) begin
         st_q  <= TC_IDLE;
         tmr_q <= '0;
      end else begin
         unique case (st_q)
            TC_IDLE: begin
               if (start) begin
                  st_q  <= TC_WAIT;
                  tmr_q <= TW'(DLY - 1);
               end
            end
            TC_WAIT: begin
               if (tmr_q == '0) begin
                  st_q  <= TC_PULSE;
                  tmr_q <= TW'(WID - 1);
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            TC_PULSE: begin
               if (tmr_q == '0) st_q <= TC_IDLE;
               else             tmr_q <= tmr_q - 1'b1;
            end
            default: st_q <= TC_IDLE;
         endcase
      end
   end

   assign pulse = (st_q == TC_PULSE);
endmodule

// File: rtl/dma_tc_gen.sv
module dma_tc_gen #(
   parameter int CNT_W     = 16,
   parameter int TC_DELAY  = 144,
   parameter int TC_WIDTH  = 4,
   parameter int REQ_DELAY = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             reg_addr,
   input  logic [CNT_W-1:0] reg_wdata,
   input  logic             cnt_clr,
   input  logic             tc_en,
   input  logic             dack_n,
   input  logic             drq_in,
   output logic             drq_out,
   output logic             tc,
   output logic [CNT_W-1:0] cnt_q
);
   localparam int SYNC_STAGES = 2;

   generate
      if (CNT_W < 2)     begin : g_bad_w   $error("CNT_W must be at least 2");    end
      if (TC_DELAY < 1)  begin : g_bad_dly $error("TC_DELAY must be at least 1"); end
      if (TC_WIDTH < 1)  begin : g_bad_wid $error("TC_WIDTH must be at least 1"); end
      if (REQ_DELAY < 0) begin : g_bad_req $error("REQ_DELAY must not be negative"); end
   endgenerate

   logic [CNT_W-1:0] max_q;
   logic             frozen_q;
   logic             ack_evt;
   logic             sw_touch;
   logic [CNT_W-1:0] cnt_nxt;
   logic             hit;
   logic             step;
   logic             tc_raw;

   dma_tc_ack_detect #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (dack_n),
      .fall_evt (ack_evt)
   );

   assign sw_touch = cnt_clr | (reg_we & reg_addr);
   assign cnt_nxt  = cnt_q + CNT_W'(1);
   assign hit      = (cnt_nxt == max_q) && (max_q != '0);
   assign step     = ack_evt & ~frozen_q & ~sw_touch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         max_q    <= '0;
         frozen_q <= 1'b0;
      end else begin
         if (reg_we && !reg_addr) max_q <= reg_wdata;
         if (cnt_clr) begin
            cnt_q    <= '0;
            frozen_q <= 1'b0;
         end else if (reg_we && reg_addr) begin
            cnt_q    <= reg_wdata;
            frozen_q <= 1'b0;
         end else if (step) begin
            cnt_q <= cnt_nxt;
            if (hit) frozen_q <= 1'b1;
         end
      end
   end

   dma_tc_timer #(.DLY(TC_DELAY), .WID(TC_WIDTH)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (step & hit),
      .abort (sw_touch),
      .pulse (tc_raw)
   );

   assign tc = tc_raw & tc_en;

   dma_tc_req_delay #(.DEPTH(REQ_DELAY)) u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (drq_in),
      .q     (drq_out)
   );
endmodule

// File: rtl/dma_tc_gen_chk.sv
module dma_tc_gen_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic             cnt_clr,
   input logic             tc,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] max_q
);
   // R1: without software access the count moves by at most one per clock
   p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reg_we) && !$past(cnt_clr)) |->
         (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

   // R3: a pulse only ever appears while the count sits on a nonzero preset
   p_tc_at_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (cnt_q == max_q && max_q != '0));

   // R8: zero preset keeps the output quiet
   p_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (max_q == '0) |-> !tc);

   // R6: the count is frozen when the pulse starts
   p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc) |-> $stable(cnt_q));
endmodule

bind dma_tc_gen dma_tc_gen_chk #(.CNT_W(CNT_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_we  (reg_we),
   .cnt_clr (cnt_clr),
   .tc      (tc),
   .cnt_q   (cnt_q),
   .max_q   (max_q)
);

// File: tb/test_dma_tc_gen.sv
module test_dma_tc_gen;
   localparam int CW = 4;
   localparam int D  = 5;
   localparam int W  = 3;
   localparam int RD = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic          reg_addr = 1'b0;
   logic [CW-1:0] reg_wdata = '0;
   logic          cnt_clr = 1'b0;
   logic          tc_en = 1'b0;
   logic          dack_n = 1'b1;
   logic          drq_in = 1'b0;
   logic          drq_out;
   logic          tc;
   logic [CW-1:0] cnt_q;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   dma_tc_gen #(.CNT_W(CW), .TC_DELAY(D), .TC_WIDTH(W), .REQ_DELAY(RD)) i_dma_tc_gen (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .cnt_clr(cnt_clr), .tc_en(tc_en), .dack_n(dack_n),
      .drq_in(drq_in), .drq_out(drq_out), .tc(tc), .cnt_q(cnt_q)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input int v);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = CW'(v);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic clr();
      @(negedge clk);
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
   endtask

   // falls the strobe, waits until the count edge has passed; strobe stays low
   task automatic ack_fall();
      @(negedge clk);
      dack_n = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic ack_rise();
      dack_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   // observes tc over a window, reports first high cycle and number of high cycles
   task automatic watch(input int len, output int first, output int highs);
      first = -1; highs = 0;
      for (int k = 1; k <= len; k++) begin
         @(negedge clk);
         if (tc) begin
            if (first < 0) first = k;
            highs++;
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int first, highs;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 count", cnt_q, 0);
      chk("R9 tc", tc, 0);
      chk("R9 drq_out", drq_out, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 count after release", cnt_q, 0);

      // R3 R4 R5 R1 R6: sweep presets with enable off and on
      for (int m = 1; m <= 7; m++) begin
         for (int en = 0; en < 2; en++) begin
            wr(1'b0, m);
            clr();
            tc_en = en[0];
            for (int a = 1; a < m; a++) begin
               ack_fall();
               ack_rise();
               chk("R1 count step", cnt_q, a);
            end
            ack_fall();
            chk("R3 count at preset", cnt_q, m);
            watch(D + W + 3, first, highs);
            chk("R4 R5 rise cycle", first, en ? D : -1);
            chk("R4 R5 pulse width", highs, en ? W : 0);
            chk("R1 long strobe counts once", cnt_q, m);
            ack_rise();
            ack_fall();
            ack_rise();
            chk("R6 frozen after match", cnt_q, m);
            watch(D + W + 3, first, highs);
            chk("R4 single pulse", highs, 0);
         end
      end

      // R2 count load, then match from loaded value
      tc_en = 1'b1;
      wr(1'b0, 7);
      wr(1'b1, 5);
      chk("R2 count load", cnt_q, 5);
      ack_fall(); ack_rise();
      chk("R2 step from loaded", cnt_q, 6);
      ack_fall();
      watch(D + W + 3, first, highs);
      chk("R2 match after load rise", first, D);
      ack_rise();
      // R2 clear wins over count write
      @(negedge clk);
      cnt_clr = 1'b1; reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 4'd9;
      @(negedge clk);
      cnt_clr = 1'b0; reg_we = 1'b0;
      chk("R2 clear priority", cnt_q, 0);
      // R6 unfrozen after clear
      ack_fall(); ack_rise();
      chk("R6 counts after clear", cnt_q, 1);

      // R6 cancel a pending pulse
      wr(1'b0, 2);
      clr();
      ack_fall(); ack_rise();
      ack_fall();
      chk("R6 pending at preset", cnt_q, 2);
      clr();
      watch(D + W + 3, first, highs);
      chk("R6 cancelled pulse", highs, 0);
      chk("R6 count cleared", cnt_q, 0);
      ack_rise();

      // R8 zero preset with wraparound
      wr(1'b0, 0);
      clr();
      highs = 0;
      for (int a = 0; a < 20; a++) begin
         ack_fall();
         if (tc) highs++;
         dack_n = 1'b1;
         for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            if (tc) highs++;
         end
      end
      watch(D + W + 3, first, first);
      chk("R8 no pulse on zero preset", highs + (first > 0 ? first : 0), 0);
      chk("R8 wrapped count", cnt_q, 20 % 16);

      // R7 request delay
      begin
         logic hist [0:63];
         for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (i >= RD) chk("R7 drq delay", drq_out, hist[i-RD]);
            hist[i] = logic'(((i * 7) ^ (i >> 2)) & 1);
            drq_in = hist[i];
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule